// File: doc/BRIEF.md
# Dual-Output Step Pulse Timer

This block is one timer channel that produces step pulses for two stepper motor outputs, A and B. A single free-running up-counter is shared by both outputs. Each output has its own compare register; when the counter matches it, that output goes high. A third compare register is shared between the two outputs. When its clear action is enabled for an output, a match on it drives that output low, and it is normally armed with a single write that loads the current count plus a fixed pulse delay.

Software sees a small register port with separate write and read strobes. Through it, software programs the compare registers, enables the clear action per output, starts and halts the counter, and reads the counter value. Each compare match on A or B raises a status flag. The flags are cleared by reading them. A single level-sensitive interrupt line is high whenever an enabled flag is set. The interrupt mask is changed only through a write-one-to-set register and a write-one-to-clear register.

Top module: `steppulse_timer`

## Requirements
- R1: After reset the counter reads 0 and is halted. A write of bit0=1 to address 0 makes the counter read 0 in the next cycle and then rise by one per clock. A write of bit1=1 to address 0 halts it. Reading address 0 returns the count.
- R2: While the counter runs, a count equal to the A compare register (address 1) drives step_a high from the next cycle on. The same holds for B with address 2 and step_b.
- R3: Address 5 holds the clear enables: bit0 for A, bit1 for B. While an output's enable is set and the counter runs, a count equal to the shared compare register (address 3) drives that output low from the next cycle on. An output whose enable is clear is not affected by that match.
- R4: When a set match and a clear match hit the same output in the same cycle, the output goes low.
- R5: Any write to address 4 loads the shared compare register with (count at that edge + DELAY) modulo 2^CNT_W. DELAY defaults to 20.
- R6: Status is read at address 4. Bit0 is set by an A compare match and bit1 by a B compare match. A read returns the flags and clears them, except that a flag whose event happens in the same cycle as the read stays set.
- R7: irq equals the OR over both flags of (flag AND mask bit). It stays high until the flags are read or the mask bit is cleared.
- R8: Writing address 6 sets the mask bits written as 1. Writing address 7 clears the mask bits written as 1. Reading address 6 or 7 returns the mask (bit0 A, bit1 B). The mask is 0 after reset.
- R9: After reset both step outputs, irq, the status flags, the clear enables and all three compare registers are zero.
- R10: When the counter wraps from its maximum value to 0, it keeps counting and no flag is raised unless a compare register matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | CNT_W | Write data |
| reg_rd | input | 1 | Read strobe (clears status when it reads address 4) |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | CNT_W | Read data, valid in the cycle of the strobe |
| step_a | output | 1 | Step waveform A |
| step_b | output | 1 | Step waveform B |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count or compare value shows up at the edges of step_a and step_b. The edge comes a cycle early or late, so the check compares each output cycle by cycle against the count of clocks since start. A bad arm computation moves the falling edge and can also be read back directly at address 3 in the next cycle. A flag that is set wrongly or cleared wrongly shows at once as an irq level that disagrees with the mask, and in the status word returned by the next read.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int NUM_OUT = 2;
  localparam logic [2:0] ADR_CTRL  = 3'd0;
  localparam logic [2:0] ADR_CMPA  = 3'd1;
  localparam logic [2:0] ADR_CMPB  = 3'd2;
  localparam logic [2:0] ADR_CMPS  = 3'd3;
  localparam logic [2:0] ADR_ARM   = 3'd4;
  localparam logic [2:0] ADR_CLREN = 3'd5;
  localparam logic [2:0] ADR_MSET  = 3'd6;
  localparam logic [2:0] ADR_MCLR  = 3'd7;
endpackage

// File: rtl/spt_counter.sv
module spt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         halt,
  output logic [W-1:0] cnt,
  output logic         run,
  output logic         wrap_evt
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c);
    return c + 1'b1;
  endfunction

  assign wrap_evt = run && (cnt == CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (halt) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= next_count(cnt);
    end
  end

  // R1: a running counter steps by exactly one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !halt) |=> (cnt == W'($past(cnt) + 1'b1)));
  // R1: a start command brings the count to zero
  a_r1_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && run));
endmodule

// File: rtl/spt_compare_bank.sv
module spt_compare_bank #(
  parameter int W     = 16,
  parameter int N     = 2,
  parameter int DELAY = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        cnt,
  input  logic                run,
  input  logic [W-1:0]        wdata,
  input  logic [N-1:0]        wr_cmp,
  input  logic                wr_shared,
  input  logic                arm,
  input  logic                wr_clren,
  output logic [N-1:0][W-1:0] cmp,
  output logic [W-1:0]        cmp_s,
  output logic [N-1:0]        clr_en,
  output logic [N-1:0]        set_hit,
  output logic [N-1:0]        clr_hit
);
  localparam logic [W-1:0] DLY = W'(DELAY);

  function automatic logic [W-1:0] arm_target(input logic [W-1:0] c);
    return c + DLY;
  endfunction

  logic shared_match;
  assign shared_match = run && (cnt == cmp_s);

  for (genvar i = 0; i < N; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp[i] <= '0;
      else if (wr_cmp[i]) cmp[i] <= wdata;
    end
    assign set_hit[i] = run && (cnt == cmp[i]);
    assign clr_hit[i] = shared_match && clr_en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_s  <= '0;
      clr_en <= '0;
    end else begin
      if (arm)            cmp_s <= arm_target(cnt);
      else if (wr_shared) cmp_s <= wdata;
      if (wr_clren)       clr_en <= wdata[N-1:0];
    end
  end

  // R5: arming loads count plus the delay
  a_r5_arm_value: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (cmp_s == W'($past(cnt) + DLY)));
endmodule

// File: rtl/spt_wave_out.sv
module spt_wave_out #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_hit,
  input  logic [N-1:0] clr_hit,
  output logic [N-1:0] wave
);
  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wave[i] <= 1'b0;
      else if (clr_hit[i]) wave[i] <= 1'b0;
      else if (set_hit[i]) wave[i] <= 1'b1;
    end

    // R2: a lone set match raises the output
    a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit[i] && !clr_hit[i]) |=> wave[i]);
    // R4: clear has priority over set
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[i] |=> !wave[i]);
    // R3: with no match the output holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_hit[i] && !clr_hit[i]) |=> $stable(wave[i]));
  end
endmodule

// File: rtl/spt_irq_status.sv
module spt_irq_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         rd_status,
  input  logic         mask_set,
  input  logic         mask_clr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags,
  output logic [N-1:0] mask,
  output logic         irq
);
  function automatic logic [N-1:0] next_flags(input logic [N-1:0] f,
                                               input logic [N-1:0] e,
                                               input logic rd);
    return (rd ? '0 : f) | e;
  endfunction

  function automatic logic [N-1:0] next_mask(input logic [N-1:0] m,
                                              input logic [N-1:0] b,
                                              input logic s, input logic c);
    return (m | (s ? b : '0)) & ~(c ? b : '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= next_flags(flags, evt, rd_status);
      mask  <= next_mask(mask, wbits, mask_set, mask_clr);
    end
  end

  assign irq = |(flags & mask);

  // R6: a read with no new event leaves no flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && evt == '0) |=> (flags == '0));
  // R6: an event is never lost, even against a read
  a_r6_keep_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
  // R7: the level holds until read or masked off
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_status && !mask_clr) |=> irq);
endmodule

// File: rtl/steppulse_timer.sv
module steppulse_timer #(
  parameter int CNT_W = 16,
  parameter int DELAY = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_waddr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             reg_rd,
  input  logic [2:0]       reg_raddr,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             step_a,
  output logic             step_b,
  output logic             irq
);
  import spt_pkg::*;
  localparam int N = NUM_OUT;

  logic [CNT_W-1:0]        cnt;
  logic                    run, wrap_evt;
  logic                    start_cmd, halt_cmd;
  logic [N-1:0]            wr_cmp;
  logic                    wr_shared, arm, wr_clren, mask_set, mask_clr, rd_status;
  logic [N-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]        cmp_s;
  logic [N-1:0]            clr_en, set_hit, clr_hit, wave, flags, mask;

  assign start_cmd = reg_wr && reg_waddr == ADR_CTRL && reg_wdata[0];
  assign halt_cmd  = reg_wr && reg_waddr == ADR_CTRL && reg_wdata[1];
  assign wr_cmp[0] = reg_wr && reg_waddr == ADR_CMPA;
  assign wr_cmp[1] = reg_wr && reg_waddr == ADR_CMPB;
  assign wr_shared = reg_wr && reg_waddr == ADR_CMPS;
  assign arm       = reg_wr && reg_waddr == ADR_ARM;
  assign wr_clren  = reg_wr && reg_waddr == ADR_CLREN;
  assign mask_set  = reg_wr && reg_waddr == ADR_MSET;
  assign mask_clr  = reg_wr && reg_waddr == ADR_MCLR;
  assign rd_status = reg_rd && reg_raddr == ADR_ARM;

  spt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start(start_cmd), .halt(halt_cmd),
    .cnt(cnt), .run(run), .wrap_evt(wrap_evt)
  );

  spt_compare_bank #(.W(CNT_W), .N(N), .DELAY(DELAY)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .run(run), .wdata(reg_wdata),
    .wr_cmp(wr_cmp), .wr_shared(wr_shared), .arm(arm), .wr_clren(wr_clren),
    .cmp(cmp), .cmp_s(cmp_s), .clr_en(clr_en),
    .set_hit(set_hit), .clr_hit(clr_hit)
  );

  spt_wave_out #(.N(N)) u_wave (
    .clk(clk), .rst_n(rst_n), .set_hit(set_hit), .clr_hit(clr_hit), .wave(wave)
  );

  spt_irq_status #(.N(N)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(set_hit), .rd_status(rd_status),
    .mask_set(mask_set), .mask_clr(mask_clr), .wbits(reg_wdata[N-1:0]),
    .flags(flags), .mask(mask), .irq(irq)
  );

  assign step_a = wave[0];
  assign step_b = wave[1];

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_raddr)
        ADR_CTRL:           reg_rdata = cnt;
        ADR_CMPA:           reg_rdata = cmp[0];
        ADR_CMPB:           reg_rdata = cmp[1];
        ADR_CMPS:           reg_rdata = cmp_s;
        ADR_ARM:            reg_rdata = CNT_W'(flags);
        ADR_CLREN:          reg_rdata = CNT_W'(clr_en);
        ADR_MSET, ADR_MCLR: reg_rdata = CNT_W'(mask);
        default:            reg_rdata = '0;
      endcase
    end
  end

  // R10: wrapping by itself raises no flag
  a_r10_wrap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && set_hit == '0 && flags == '0) |=> (flags == '0));
  // R8: a mask-set write turns its bits on
  a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set && !mask_clr) |=> ((mask & $past(reg_wdata[N-1:0])) == $past(reg_wdata[N-1:0])));
  // R8: a mask-clear write turns its bits off
  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    mask_clr |=> ((mask & $past(reg_wdata[N-1:0])) == '0));
endmodule

// File: tb/sim_steppulse_timer.sv
module sim_steppulse_timer;
  localparam int W = 8;
  localparam int D = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]   reg_waddr = '0, reg_raddr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         step_a, step_b, irq;

  int n_chk = 0, n_bad = 0, cyc = 0;

  steppulse_timer #(.CNT_W(W), .DELAY(D)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .step_a(step_a), .step_b(step_b), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [W-1:0] exp_arm(input logic [W-1:0] c);
    return W'((int'(c) + D) % (1 << W));
  endfunction

  function automatic logic exp_irq(input logic fa, input logic fb, input logic [1:0] m);
    return (fa & m[0]) | (fb & m[1]);
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 100000);
      summary();
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = W'(d);
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_rd = 1'b1; reg_raddr = a;
    #1 v = int'(reg_rdata);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ticks(2);
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    int v, c, va, vb, m, ea, eb, ei;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();

    // R9 / R8 / R1 reset state
    rd(3'd0, v); check("R1 count after reset", v, 0);
    rd(3'd0, v); check("R1 halted after reset", v, 0);
    rd(3'd1, v); check("R9 cmpA reset", v, 0);
    rd(3'd2, v); check("R9 cmpB reset", v, 0);
    rd(3'd3, v); check("R9 shared reset", v, 0);
    rd(3'd5, v); check("R9 clren reset", v, 0);
    rd(3'd6, v); check("R8 mask reset", v, 0);
    rd(3'd4, v); check("R9 status reset", v, 0);
    check("R9 outputs reset", {step_a, step_b, irq}, 0);

    // R1 start, count, halt
    wr(3'd1, 200); wr(3'd2, 210);
    wr(3'd0, 1);
    rd(3'd0, v); check("R1 zero after start", v, 0);
    rd(3'd0, v); check("R1 step", v, 1);
    ticks(5);
    rd(3'd0, v); check("R1 counting", v, 7);
    wr(3'd0, 2);
    rd(3'd0, v); c = v;
    ticks(3);
    rd(3'd0, v); check("R1 halt holds", v, c);

    // R2 / R6 / R7 random compare placement
    for (int it = 0; it < 5; it++) begin
      int err_a, err_b, err_i;
      err_a = 0; err_b = 0; err_i = 0;
      va = 2 + int'($urandom % 90);
      vb = va + 1 + int'($urandom % 8);
      m  = int'($urandom % 4);
      do_reset();
      wr(3'd6, m);
      wr(3'd1, va); wr(3'd2, vb);
      wr(3'd0, 1);
      for (int j = 1; j <= 110; j++) begin
        tick();
        ea = (j >= va + 1) ? 1 : 0;
        eb = (j >= vb + 1) ? 1 : 0;
        ei = int'(exp_irq(ea[0], eb[0], m[1:0]));
        if (int'(step_a) != ea) err_a++;
        if (int'(step_b) != eb) err_b++;
        if (int'(irq) != ei) err_i++;
      end
      check("R2 step_a edge timing", err_a, 0);
      check("R2 step_b edge timing", err_b, 0);
      check("R7 irq level tracks mask", err_i, 0);
      rd(3'd4, v); check("R6 status both flags", v, 3);
      rd(3'd4, v); check("R6 status cleared by read", v, 0);
      check("R7 irq drops after read", int'(irq), 0);
    end

    // R5 / R3 arm the shared compare, clear only A
    wr(3'd5, 1);
    reg_wr = 1'b1; reg_waddr = 3'd4; reg_wdata = '0;
    reg_rd = 1'b1; reg_raddr = 3'd0;
    #1 c = int'(reg_rdata);
    tick();
    reg_wr = 1'b0; reg_rd = 1'b0;
    rd(3'd3, v); check("R5 armed value", v, int'(exp_arm(W'(c))));
    ticks(18);
    check("R3 step_a still high before delay", int'(step_a), 1);
    tick();
    check("R3 step_a cleared after delay", int'(step_a), 0);
    check("R3 step_b not cleared when disabled", int'(step_b), 1);

    // R4 set and clear on the same count
    do_reset();
    wr(3'd1, 50); wr(3'd2, 200); wr(3'd3, 50); wr(3'd5, 1);
    wr(3'd0, 1);
    ticks(51);
    check("R4 clear wins", int'(step_a), 0);
    rd(3'd4, v); check("R4 flag still raised", v, 1);

    // R6 event in the read cycle is kept; R7 level holds
    do_reset();
    wr(3'd6, 3);
    wr(3'd1, 10); wr(3'd2, 200);
    wr(3'd0, 1);
    ticks(10);
    rd(3'd4, v); check("R6 read before event", v, 0);
    ticks(30);
    check("R7 irq held high", int'(irq), 1);
    rd(3'd4, v); check("R6 event kept across read", v, 1);
    check("R7 irq low after read", int'(irq), 0);

    // R8 mask set and clear
    wr(3'd6, 3); rd(3'd6, v); check("R8 mask set", v, 3);
    wr(3'd7, 1); rd(3'd7, v); check("R8 mask clear", v, 2);
    wr(3'd6, 0); rd(3'd6, v); check("R8 zero bits ignored", v, 2);

    // R10 wrap without flags
    do_reset();
    wr(3'd6, 3);
    wr(3'd1, 100); wr(3'd2, 100);
    wr(3'd0, 1);
    ticks(150);
    rd(3'd4, v); check("R10 flags before wrap", v, 3);
    ticks(110);
    rd(3'd0, v); check("R10 count wrapped", v, 5);
    rd(3'd4, v); check("R10 no flag from wrap", v, 0);
    check("R10 irq quiet", int'(irq), 0);

    summary();
  end
endmodule